// File: doc/BRIEF.md
# Bus Clock Restart Requester

This block sits beside a low-pin-count host bus whose clock may be stopped by a central clock resource. The shared clock-status line is open-drain and pulled up: a high level means the bus clock is stopped or stopping, and a low level means it is starting or running. When the serial interrupt function is enabled, any change on a local interrupt input asks the central resource to restart the bus clock. The block does this by pulling the shared line low through its open-drain enable.

Interrupt inputs are watched in an always-running local clock domain, so a change is seen even while the bus clock is stopped. The pulldown is started from that domain and never waits for a bus clock edge. It is released once two rising bus clock edges have been counted. In the bus clock domain the block also tracks whether the line was high on two successive bus edges. It never pulls a line that is already low, never pulls one that was not seen idle for two edges, and never acts while the mode is disabled.

The controller is a three-state machine. The states are IDLE (released), DRIVE (pulling low) and WAIT2 (released, waiting for the edge counter to clear). The transitions are:
- START, IDLE to DRIVE: enabled, change pending, line high, idle seen, counter clear.
- COUNTED, DRIVE to WAIT2: two bus edges counted.
- ABORT, DRIVE to IDLE: mode disabled.
- SETTLED, WAIT2 to IDLE: counter cleared; this also clears the pending change.

Top module: `clk_restart_req`

## Requirements
- R1: During and right after reset `pull_en` is 0.
- R2: While `sirq_en` is 0, `pull_en` stays 0. A change made while it is 0 has no effect, even after `sirq_en` later returns to 1.
- R3: With `sirq_en`=1, the line high and idle seen, a rising or a falling edge on any single `irq_in` bit sets `pull_en` to 1 within 6 `lclk` cycles. No `bclk` edge is needed for this.
- R4: Several `irq_in` bits changing together give one request, exactly as a single-bit change does.
- R5: Once set, `pull_en` stays 1 across the first rising `bclk` edge. It returns to 0 within 5 `lclk` cycles after the second rising `bclk` edge.
- R6: If the line is already low, driven by the central resource, when a change occurs, `pull_en` stays 0.
- R7: `pull_en` is set only if `line_in` was sampled high on at least two successive rising `bclk` edges since the last low sample. With zero or one such edge it stays 0.
- R8: With no `irq_in` change, `pull_en` stays 0. After a release it is not set again without a new change.
- R9: Clearing `sirq_en` while `pull_en` is 1 releases it within 2 `lclk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lclk | input | 1 | Always-running local clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bclk | input | 1 | Bus clock; may be stopped |
| sirq_en | input | 1 | Serial interrupt mode enable (1 = restart support on) |
| irq_in | input | N_IRQ | Parallel interrupt request lines |
| line_in | input | 1 | Sampled level of the shared clock-status line |
| pull_en | output | 1 | Open-drain pulldown enable (1 = pull the line low) |

## Verification
The main function is tried with rising, falling and multi-bit interrupt changes. This separates detection of either edge from a one-direction or one-bit compare. The same changes are replayed against a line primed with zero, one and two high bus edges, which finds an idle check that is off by one. They are also replayed against a line held low by a separate central driver, and with the mode disabled. That shows each blocking rule acts alone. The release is probed after one and after two bus edges, and again later to catch a request that fires a second time.

// File: rtl/crr_pkg.sv
package crr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_WAIT2 = 2'd2
    } crr_state_e;
endpackage

// File: rtl/crr_sync.sv
module crr_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/crr_irq_change.sv
module crr_irq_change #(
    parameter int N = 4
) (
    input  logic         lclk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    output logic         change
);
    logic [N-1:0] irq_s;
    logic [N-1:0] prev;
    logic [2:0]   vld;

    crr_sync #(.W(N)) u_sync (
        .clk   (lclk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (irq_s)
    );

    // prev becomes a valid copy only once the synchronizer has filled
    always_ff @(posedge lclk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
            vld  <= '0;
        end else begin
            prev <= irq_s;
            vld  <= {vld[1:0], 1'b1};
        end
    end

    assign change = vld[2] && (irq_s != prev);
endmodule

// File: rtl/crr_bus_edges.sv
module crr_bus_edges #(
    parameter int IDLE_EDGES = 2,
    parameter int HOLD_EDGES = 2
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic line_in,
    input  logic pull_en,
    output logic idle_ok,
    output logic edges_done
);
    localparam int IW = $clog2(IDLE_EDGES + 1);
    localparam int HW = $clog2(HOLD_EDGES + 1);
    localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_EDGES);
    localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_EDGES);

    logic [IW-1:0] hi_cnt;
    logic [HW-1:0] hold_cnt;
    logic          hold_rst_n;

    // successive high samples; holds its value while the clock is stopped
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!line_in)
            hi_cnt <= '0;
        else if (hi_cnt != IDLE_MAX)
            hi_cnt <= hi_cnt + 1'b1;
    end

    // edge counter held clear whenever the pulldown is off
    assign hold_rst_n = rst_n & pull_en;

    always_ff @(posedge bclk or negedge hold_rst_n) begin
        if (!hold_rst_n)
            hold_cnt <= '0;
        else if (hold_cnt != HOLD_MAX)
            hold_cnt <= hold_cnt + 1'b1;
    end

    assign idle_ok    = (hi_cnt == IDLE_MAX);
    assign edges_done = (hold_cnt == HOLD_MAX);
endmodule

// File: rtl/clk_restart_req.sv
module clk_restart_req
    import crr_pkg::*;
#(
    parameter int N_IRQ      = 4,
    parameter int IDLE_EDGES = 2,
    parameter int HOLD_EDGES = 2
) (
    input  logic             lclk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             sirq_en,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             line_in,
    output logic             pull_en
);
    logic       change;
    logic       idle_b, done_b;
    logic       line_s, idle_s, done_s;
    logic       pending;
    crr_state_e state, next;

    crr_irq_change #(.N(N_IRQ)) u_chg (
        .lclk   (lclk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .change (change)
    );

    crr_bus_edges #(.IDLE_EDGES(IDLE_EDGES), .HOLD_EDGES(HOLD_EDGES)) u_bus (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .pull_en    (pull_en),
        .idle_ok    (idle_b),
        .edges_done (done_b)
    );

    crr_sync #(.W(3)) u_back (
        .clk   (lclk),
        .rst_n (rst_n),
        .d     ({line_in, idle_b, done_b}),
        .q     ({line_s, idle_s, done_s})
    );

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:  if (sirq_en && pending && line_s && idle_s && !done_s)
                          next = ST_DRIVE;
            ST_DRIVE: if (!sirq_en)
                          next = ST_IDLE;
                      else if (done_s)
                          next = ST_WAIT2;
            ST_WAIT2: if (!done_s)
                          next = ST_IDLE;
            default:  next = ST_IDLE;
        endcase
    end

    always_ff @(posedge lclk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= next;
    end

    // registered output: glitch-free, it also clears the bus edge counter
    always_ff @(posedge lclk or negedge rst_n) begin
        if (!rst_n)
            pull_en <= 1'b0;
        else
            pull_en <= (next == ST_DRIVE);
    end

    always_ff @(posedge lclk or negedge rst_n) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (!sirq_en)
            pending <= 1'b0;
        else if (change)
            pending <= 1'b1;
        else if (state == ST_WAIT2 && next == ST_IDLE)
            pending <= 1'b0;
        else if (state == ST_IDLE && !line_s)
            pending <= 1'b0;
    end
endmodule

// File: rtl/crr_chk.sv
module crr_chk (
    input logic lclk,
    input logic rst_n,
    input logic sirq_en,
    input logic pull_en,
    input logic line_s,
    input logic idle_s,
    input logic done_s,
    input logic pending
);
    // R2
    no_drive_disabled_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        !sirq_en |=> !pull_en);

    // R6 R7
    drive_gate_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        $rose(pull_en) |-> ($past(line_s) && $past(idle_s)));

    // R5
    hold_until_count_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        (pull_en && sirq_en && !done_s) |=> pull_en);

    // R5
    release_after_count_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        (pull_en && done_s) |=> !pull_en);

    // R8
    no_spurious_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        (!pull_en && !pending) |=> !pull_en);
endmodule

bind clk_restart_req crr_chk u_chk (
    .lclk    (lclk),
    .rst_n   (rst_n),
    .sirq_en (sirq_en),
    .pull_en (pull_en),
    .line_s  (line_s),
    .idle_s  (idle_s),
    .done_s  (done_s),
    .pending (pending)
);

// File: tb/sim_clk_restart_req.sv
module sim_clk_restart_req;
    typedef struct packed {
        logic       en;
        logic [1:0] highs;
        logic       cen_now;
        logic [3:0] base;
        logic [3:0] mask;
        logic       exp;
    } vec_t;

    // en, high bus edges before stop, central low at change, base, toggle, expect
    localparam vec_t VEC [9] = '{
        '{1'b1, 2'd2, 1'b0, 4'b0000, 4'b0001, 1'b1},  // R3 rising bit0
        '{1'b1, 2'd3, 1'b0, 4'b0000, 4'b1000, 1'b1},  // R3 rising bit3
        '{1'b1, 2'd2, 1'b0, 4'b0001, 4'b0001, 1'b1},  // R3 falling bit0
        '{1'b1, 2'd2, 1'b0, 4'b0100, 4'b0110, 1'b1},  // R4 multi-bit
        '{1'b0, 2'd2, 1'b0, 4'b0000, 4'b0001, 1'b0},  // R2 disabled
        '{1'b1, 2'd2, 1'b1, 4'b0000, 4'b0001, 1'b0},  // R6 central low
        '{1'b1, 2'd1, 1'b0, 4'b0000, 4'b0001, 1'b0},  // R7 one high edge
        '{1'b1, 2'd0, 1'b0, 4'b0000, 4'b0001, 1'b0},  // R7 no high edge
        '{1'b1, 2'd2, 1'b0, 4'b0000, 4'b0000, 1'b0}   // R8 no change
    };

    logic       lclk = 1'b0;
    logic       bclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sirq_en = 1'b0;
    logic       central = 1'b0;
    logic [3:0] irq = 4'b0000;
    logic       pull_en;
    logic       line;
    int         checks = 0;
    int         fails = 0;
    logic       finished = 1'b0;

    assign line = !(pull_en || central);

    always #5 lclk = ~lclk;

    clk_restart_req u0 (
        .lclk    (lclk),
        .rst_n   (rst_n),
        .bclk    (bclk),
        .sirq_en (sirq_en),
        .irq_in  (irq),
        .line_in (line),
        .pull_en (pull_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic lwait(input int n);
        repeat (n) @(negedge lclk);
    endtask

    task automatic bedge();
        #3 bclk = 1'b1;
        #7 bclk = 1'b0;
        #3;
    endtask

    task automatic start(input logic en, input logic [3:0] base);
        rst_n = 1'b0;
        central = 1'b0;
        sirq_en = en;
        irq = base;
        lwait(3);
        rst_n = 1'b1;
        lwait(5);
    endtask

    task automatic prime(input int highs);
        central = 1'b1;
        bedge();
        bedge();
        central = 1'b0;
        for (int k = 0; k < highs; k++) bedge();
    endtask

    initial begin
        // R1 reset state
        lwait(2);
        chk("R1 in reset", pull_en, 1'b0);
        start(1'b1, 4'b0000);
        chk("R1 after reset", pull_en, 1'b0);

        for (int i = 0; i < 9; i++) begin
            start(VEC[i].en, VEC[i].base);
            prime(int'(VEC[i].highs));
            central = VEC[i].cen_now;
            lwait(6);
            irq = irq ^ VEC[i].mask;
            lwait(6);
            chk($sformatf("R3 vec%0d pull", i), pull_en, VEC[i].exp);
            if (VEC[i].exp) begin
                chk("R3 line low", line, 1'b0);
                bedge();
                lwait(8);
                chk("R5 held after first edge", pull_en, 1'b1);
                bedge();
                lwait(5);
                chk("R5 released after second edge", pull_en, 1'b0);
                lwait(10);
                chk("R8 no re-drive", pull_en, 1'b0);
            end
        end

        // R2 change while disabled has no effect after enabling
        start(1'b0, 4'b0000);
        prime(2);
        irq = 4'b0010;
        lwait(10);
        sirq_en = 1'b1;
        lwait(10);
        chk("R2 stale change", pull_en, 1'b0);

        // R9 disable during drive
        start(1'b1, 4'b0000);
        prime(2);
        lwait(6);
        irq = 4'b0001;
        lwait(6);
        chk("R9 driving", pull_en, 1'b1);
        sirq_en = 1'b0;
        lwait(2);
        chk("R9 released on disable", pull_en, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule